// File: doc/BRIEF.md
# Flow Cache Exception Steering

This block makes the forwarding decision for each packet descriptor in a virtual-switch offload pipeline. A descriptor carries a 104-bit flow key (IPv4 addresses, L4 ports and protocol), the TCP flag byte and the packet's VLAN tag state. The key is compared exactly against a small flow cache that software fills through a write port. On a clean hit, the descriptor leaves toward the port stored in the matching rule. On a miss, or on a hit to a rule that software has marked stale, the descriptor is an exception. It is steered to the hypervisor port, and its VLAN ID is overwritten with a reserved marker so that software can spot it. A tag is inserted first when the packet has none.

TCP packets that open or close a connection are also copied to software. When such a packet hits a clean rule, the block emits two descriptors on consecutive output transfers. The original goes to the rule's port, and an identical copy goes to the hypervisor port. A terminating packet that misses produces only the single exception descriptor.

The controller is a three-state machine. ST_EMPTY means no output is held. ST_ONE means one descriptor is presented. ST_DUP means an original is presented and its copy is still owed. The transitions are:

- ACCEPT_SINGLE: ST_EMPTY or ST_ONE goes to ST_ONE.
- ACCEPT_DUP: ST_EMPTY or ST_ONE goes to ST_DUP.
- DRAIN: ST_ONE goes to ST_EMPTY when the output is taken and nothing new arrives.
- EMIT_COPY: ST_DUP goes to ST_ONE when the original is taken.
- HOLD: any state stays put while the output is stalled.

Top module: `flow_steer`

## Requirements
- R1: A lookup hits only if a valid entry's stored key equals the 104-bit key in every bit. The key is laid out as {src_ip[103:72], dst_ip[71:40], src_l4[39:24], dst_l4[23:8], proto[7:0]}. Any single differing bit is a miss. When several entries match, the lowest index wins.
- R2: A hit on a non-stale entry with no termination condition produces exactly one output descriptor. That descriptor carries the entry's port, the input VLAN present flag and VLAN ID unchanged, out_exception=0, out_copy=0 and out_vlan_inserted=0.
- R3: A miss produces exactly one output descriptor. It goes to port HV_PORT, with out_vlan_id=EXC_VID (default 12'hFFF), out_vlan_present=1, out_exception=1 and out_copy=0.
- R4: For an exception descriptor, out_vlan_inserted is 1 when the input had no VLAN tag and 0 when it had one. Non-exception descriptors always have out_vlan_inserted=0.
- R5: A hit on an entry whose stale bit is set is handled exactly like a miss (R3, R4). This repeats for every later packet of that flow until software rewrites the entry with the stale bit clear.
- R6: A packet is terminating when proto equals 6 and any of flag bits 0 (FIN), 1 (SYN) or 2 (RST) is set. A terminating packet that hits a non-stale entry produces two descriptors on consecutive output transfers. The first is the original (entry port, out_copy=0). The second has port HV_PORT and out_copy=1, with key, flags and VLAN fields identical to the original. in_ready is low while the copy is owed.
- R7: A terminating packet that misses, and a non-TCP packet (proto other than 6) that has flag bits 0 to 2 set, each produce a single descriptor with no copy.
- R8: A pulse on wr_en writes wr_key, wr_port, wr_valid and wr_stale into entry wr_idx. The new contents govern every descriptor accepted on later cycles. Writing wr_valid=0 removes the rule.
- R9: The input handshake is in_valid/in_ready and the output handshake is out_valid/out_ready. While out_valid is high and out_ready is low, every output field holds steady. Descriptors leave in the order they arrived, and none is lost or repeated.
- R10: After reset, out_valid is 0, in_ready is 1 and every cache entry is invalid, so the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Block can accept a descriptor |
| in_key | input | 104 | Flow key, layout in R1 |
| in_tcp_flags | input | 8 | TCP flag byte (bit0 FIN, bit1 SYN, bit2 RST) |
| in_vlan_present | input | 1 | Input packet carries a VLAN tag |
| in_vlan_id | input | 12 | Input VLAN ID |
| out_valid | output | 1 | Output descriptor valid |
| out_ready | input | 1 | Downstream takes the descriptor |
| out_key | output | 104 | Flow key of the output descriptor |
| out_tcp_flags | output | 8 | TCP flag byte of the output descriptor |
| out_vlan_present | output | 1 | Output carries a VLAN tag |
| out_vlan_id | output | 12 | Output VLAN ID |
| out_vlan_inserted | output | 1 | A tag was added by this block |
| out_port | output | PORT_W | Destination port |
| out_exception | output | 1 | Descriptor is an exception for software |
| out_copy | output | 1 | Descriptor is the monitoring copy of a terminating packet |
| wr_en | input | 1 | Cache write strobe |
| wr_idx | input | log2(ENTRIES) | Entry index to write |
| wr_key | input | 104 | Key to store |
| wr_port | input | PORT_W | Port to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_stale | input | 1 | Stale bit to store |

## Verification
The bench builds the block with ENTRIES=4 and HV_PORT=14. The small cache lets a rule sit at the highest index and be rewritten or dropped within a few cycles. Because the hypervisor port is not all ones, a mistake that puts the all-ones value or the rule's port on an exception becomes visible. With PORT_W=4 and the default EXC_VID, the reserved marker and the hypervisor port are distinct values that the checks tell apart. The stalled-output scenarios catch the controller in ST_ONE and ST_DUP, so held fields and the dropped in_ready can be seen at the ports.

// File: rtl/flow_steer_pkg.sv
package flow_steer_pkg;
    localparam int IP_W    = 32;
    localparam int L4_W    = 16;
    localparam int PROTO_W = 8;
    localparam int KEY_W   = 2 * IP_W + 2 * L4_W + PROTO_W;
    localparam int FLAG_W  = 8;
    localparam int VID_W   = 12;

    localparam logic [PROTO_W-1:0] PROTO_TCP = 8'd6;
    // bit 0 FIN, bit 1 SYN, bit 2 RST
    localparam logic [FLAG_W-1:0]  TERM_MASK = 8'h07;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd1,
        ST_DUP   = 2'd2
    } steer_state_e;
endpackage

// File: rtl/fs_flow_table.sv
module fs_flow_table
    import flow_steer_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PORT_W  = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [KEY_W-1:0]          wr_key,
    input  logic [PORT_W-1:0]         wr_port,
    input  logic                      wr_valid,
    input  logic                      wr_stale,
    input  logic [KEY_W-1:0]          lk_key,
    output logic [ENTRIES-1:0]        match_vec,
    output logic [ENTRIES*PORT_W-1:0] ent_port,
    output logic [ENTRIES-1:0]        ent_stale
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [KEY_W-1:0]  key_q;
        logic [PORT_W-1:0] port_q;
        logic              vld_q;
        logic              stl_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                key_q  <= '0;
                port_q <= '0;
                vld_q  <= 1'b0;
                stl_q  <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                key_q  <= wr_key;
                port_q <= wr_port;
                vld_q  <= wr_valid;
                stl_q  <= wr_stale;
            end
        end

        assign match_vec[e]                  = vld_q && (key_q == lk_key);
        assign ent_port[e*PORT_W +: PORT_W] = port_q;
        assign ent_stale[e]                  = stl_q;
    end

    // R8: a rule written valid matches its own key on the next cycle
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_valid) && (lk_key == $past(wr_key)))
        |-> match_vec[$past(wr_idx)]);

    // R8: a rule written invalid never matches afterwards
    a_r8_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(wr_valid)) |-> !match_vec[$past(wr_idx)]);
endmodule

// File: rtl/fs_hit_select.sv
module fs_hit_select #(
    parameter int ENTRIES = 16,
    parameter int PORT_W  = 4
) (
    input  logic [ENTRIES-1:0]        match_vec,
    input  logic [ENTRIES*PORT_W-1:0] ent_port,
    input  logic [ENTRIES-1:0]        ent_stale,
    output logic                      hit,
    output logic [PORT_W-1:0]         hit_port,
    output logic                      hit_stale
);
    // lowest matching index has priority: scan downward, last write wins
    always_comb begin
        hit       = 1'b0;
        hit_port  = '0;
        hit_stale = 1'b0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match_vec[e]) begin
                hit       = 1'b1;
                hit_port  = ent_port[e*PORT_W +: PORT_W];
                hit_stale = ent_stale[e];
            end
        end
    end
endmodule

// File: rtl/flow_steer.sv
module flow_steer
    import flow_steer_pkg::*;
#(
    parameter int                ENTRIES = 16,
    parameter int                PORT_W  = 4,
    parameter logic [PORT_W-1:0] HV_PORT = '1,
    parameter logic [VID_W-1:0]  EXC_VID = 12'hFFF,
    localparam int               IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [KEY_W-1:0]   in_key,
    input  logic [FLAG_W-1:0]  in_tcp_flags,
    input  logic               in_vlan_present,
    input  logic [VID_W-1:0]   in_vlan_id,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [KEY_W-1:0]   out_key,
    output logic [FLAG_W-1:0]  out_tcp_flags,
    output logic               out_vlan_present,
    output logic [VID_W-1:0]   out_vlan_id,
    output logic               out_vlan_inserted,
    output logic [PORT_W-1:0]  out_port,
    output logic               out_exception,
    output logic               out_copy,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [PORT_W-1:0]  wr_port,
    input  logic               wr_valid,
    input  logic               wr_stale
);
    logic [ENTRIES-1:0]        match_vec;
    logic [ENTRIES*PORT_W-1:0] ent_port;
    logic [ENTRIES-1:0]        ent_stale;
    logic                      hit;
    logic [PORT_W-1:0]         hit_port;
    logic                      hit_stale;

    fs_flow_table #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_key    (wr_key),
        .wr_port   (wr_port),
        .wr_valid  (wr_valid),
        .wr_stale  (wr_stale),
        .lk_key    (in_key),
        .match_vec (match_vec),
        .ent_port  (ent_port),
        .ent_stale (ent_stale)
    );

    fs_hit_select #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_select (
        .match_vec (match_vec),
        .ent_port  (ent_port),
        .ent_stale (ent_stale),
        .hit       (hit),
        .hit_port  (hit_port),
        .hit_stale (hit_stale)
    );

    // decision for the descriptor currently on the input
    logic is_exc;
    logic is_term;
    logic need_dup;

    assign is_exc   = !hit || hit_stale;
    assign is_term  = (in_key[PROTO_W-1:0] == PROTO_TCP) && |(in_tcp_flags & TERM_MASK);
    assign need_dup = is_term && !is_exc;

    steer_state_e state_q, state_d;
    logic         accept;
    logic         load_copy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state and handshake outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_copy = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = need_dup ? ST_DUP : ST_ONE;
            end
            ST_ONE: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready) begin
                    if (in_valid) state_d = need_dup ? ST_DUP : ST_ONE;
                    else          state_d = ST_EMPTY;
                end
            end
            ST_DUP: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    load_copy = 1'b1;
                    state_d   = ST_ONE;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign accept = in_valid && in_ready;

    // output descriptor register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_key           <= '0;
            out_tcp_flags     <= '0;
            out_vlan_present  <= 1'b0;
            out_vlan_id       <= '0;
            out_vlan_inserted <= 1'b0;
            out_port          <= '0;
            out_exception     <= 1'b0;
            out_copy          <= 1'b0;
        end else if (accept) begin
            out_key           <= in_key;
            out_tcp_flags     <= in_tcp_flags;
            out_vlan_present  <= is_exc ? 1'b1 : in_vlan_present;
            out_vlan_id       <= is_exc ? EXC_VID : in_vlan_id;
            out_vlan_inserted <= is_exc && !in_vlan_present;
            out_port          <= is_exc ? HV_PORT : hit_port;
            out_exception     <= is_exc;
            out_copy          <= 1'b0;
        end else if (load_copy) begin
            out_port <= HV_PORT;
            out_copy <= 1'b1;
        end
    end

    // R3: exception descriptors carry the marker and go to the hypervisor
    a_r3_exc_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_exception)
        |-> (out_vlan_id == EXC_VID) && (out_port == HV_PORT) && out_vlan_present);

    // R6: once the original leaves from ST_DUP, the copy is presented next
    a_r6_copy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (state_q == ST_DUP))
        |=> (out_valid && out_copy && (out_port == HV_PORT)));

    // R6: no input is taken while a copy is owed
    a_r6_dup_stalls_input: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DUP) |-> !in_ready);

    // R7: a copy is never an exception descriptor
    a_r7_copy_not_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_copy) |-> !out_exception);

    // R9: a stalled output holds every field
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready)
        |=> (out_valid && $stable(out_key) && $stable(out_port) && $stable(out_copy)
             && $stable(out_vlan_id) && $stable(out_exception)));
endmodule

// File: tb/sim_flow_steer.sv
module sim_flow_steer;
    import flow_steer_pkg::*;

    localparam int         ENT = 4;
    localparam int         PW  = 4;
    localparam logic [3:0] HV  = 4'hE;
    localparam int         IW  = 2;

    logic              clk;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [KEY_W-1:0]  in_key;
    logic [FLAG_W-1:0] in_tcp_flags;
    logic              in_vlan_present;
    logic [VID_W-1:0]  in_vlan_id;
    logic              out_valid;
    logic              out_ready;
    logic [KEY_W-1:0]  out_key;
    logic [FLAG_W-1:0] out_tcp_flags;
    logic              out_vlan_present;
    logic [VID_W-1:0]  out_vlan_id;
    logic              out_vlan_inserted;
    logic [PW-1:0]     out_port;
    logic              out_exception;
    logic              out_copy;
    logic              wr_en;
    logic [IW-1:0]     wr_idx;
    logic [KEY_W-1:0]  wr_key;
    logic [PW-1:0]     wr_port;
    logic              wr_valid;
    logic              wr_stale;

    flow_steer #(.ENTRIES(ENT), .PORT_W(PW), .HV_PORT(HV)) u0 (.*);

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // capture of completed output transfers
    logic [KEY_W-1:0] cap_key  [16];
    logic [PW-1:0]    cap_port [16];
    logic [VID_W-1:0] cap_vid  [16];
    logic             cap_vp   [16];
    logic             cap_exc  [16];
    logic             cap_ins  [16];
    logic             cap_copy [16];
    int               cap_cyc  [16];
    int               ncap = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && ncap < 16) begin
            cap_key[ncap]  = out_key;
            cap_port[ncap] = out_port;
            cap_vid[ncap]  = out_vlan_id;
            cap_vp[ncap]   = out_vlan_present;
            cap_exc[ncap]  = out_exception;
            cap_ins[ncap]  = out_vlan_inserted;
            cap_copy[ncap] = out_copy;
            cap_cyc[ncap]  = cyc;
            ncap = ncap + 1;
        end
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [KEY_W-1:0] mk(logic [31:0] s, logic [31:0] d,
                                            logic [15:0] sp, logic [15:0] dp,
                                            logic [7:0] pr);
        return {s, d, sp, dp, pr};
    endfunction

    task automatic do_write(int idx, logic [KEY_W-1:0] k, logic [PW-1:0] p, bit v, bit s);
        @(negedge clk);
        wr_idx   = IW'(idx);
        wr_key   = k;
        wr_port  = p;
        wr_valid = v;
        wr_stale = s;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic send(logic [KEY_W-1:0] k, logic [7:0] f, bit vp, logic [11:0] vid);
        @(negedge clk);
        in_key          = k;
        in_tcp_flags    = f;
        in_vlan_present = vp;
        in_vlan_id      = vid;
        in_valid        = 1'b1;
        #1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_ready(bit v);
        @(posedge clk);
        #1 out_ready = v;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_single(string req, int port, int vid, bit vp, bit exc, bit ins);
        chk(req, "count", 128'(ncap), 128'd1);
        chk(req, "port", 128'(cap_port[0]), 128'(port));
        chk(req, "vid", 128'(cap_vid[0]), 128'(vid));
        chk(req, "vlan_present", 128'(cap_vp[0]), 128'(vp));
        chk(req, "exception", 128'(cap_exc[0]), 128'(exc));
        chk(req, "inserted", 128'(cap_ins[0]), 128'(ins));
        chk(req, "copy", 128'(cap_copy[0]), 128'd0);
    endtask

    logic [KEY_W-1:0] k1, k1b, k2, k3;

    task automatic t_reset();
        #1;
        chk("R10", "in_ready", 128'(in_ready), 128'd1);
        chk("R10", "out_valid", 128'(out_valid), 128'd0);
        ncap = 0;
        send(k1, 8'h10, 1'b1, 12'd100);
        drain();
        expect_single("R10", HV, 12'hFFF, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_hit();
        do_write(3, k1, 4'd5, 1'b1, 1'b0);
        do_write(0, k2, 4'd2, 1'b1, 1'b0);
        ncap = 0;
        send(k1, 8'h10, 1'b1, 12'd100);
        drain();
        expect_single("R2", 5, 100, 1'b1, 1'b0, 1'b0);
        chk("R2", "key", 128'(cap_key[0]), 128'(k1));
        ncap = 0;
        send(k2, 8'h00, 1'b0, 12'd0);
        drain();
        expect_single("R2", 2, 0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_miss();
        ncap = 0;
        send(k1b, 8'h10, 1'b1, 12'd77);
        drain();
        expect_single("R1", HV, 12'hFFF, 1'b1, 1'b1, 1'b0);
        ncap = 0;
        send(k3, 8'h00, 1'b0, 12'd0);
        drain();
        expect_single("R4", HV, 12'hFFF, 1'b1, 1'b1, 1'b1);
        chk("R3", "key", 128'(cap_key[0]), 128'(k3));
    endtask

    task automatic t_term();
        ncap = 0;
        send(k1, 8'h02, 1'b1, 12'd100);
        drain();
        chk("R6", "count", 128'(ncap), 128'd2);
        chk("R6", "orig port", 128'(cap_port[0]), 128'd5);
        chk("R6", "orig copy", 128'(cap_copy[0]), 128'd0);
        chk("R6", "copy port", 128'(cap_port[1]), 128'(HV));
        chk("R6", "copy flag", 128'(cap_copy[1]), 128'd1);
        chk("R6", "copy vid", 128'(cap_vid[1]), 128'd100);
        chk("R6", "copy exc", 128'(cap_exc[1]), 128'd0);
        chk("R6", "copy key", 128'(cap_key[1]), 128'(k1));
        chk("R6", "back to back", 128'(cap_cyc[1]), 128'(cap_cyc[0] + 1));
        ncap = 0;
        send(k1, 8'h04, 1'b1, 12'd100);
        drain();
        chk("R6", "rst count", 128'(ncap), 128'd2);
        ncap = 0;
        send(k3, 8'h01, 1'b1, 12'd9);
        drain();
        expect_single("R7", HV, 12'hFFF, 1'b1, 1'b1, 1'b0);
        ncap = 0;
        send(k2, 8'h07, 1'b1, 12'd9);
        drain();
        expect_single("R7", 2, 9, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_stale();
        do_write(3, k1, 4'd5, 1'b1, 1'b1);
        ncap = 0;
        send(k1, 8'h10, 1'b0, 12'd0);
        drain();
        expect_single("R5", HV, 12'hFFF, 1'b1, 1'b1, 1'b1);
        ncap = 0;
        send(k1, 8'h02, 1'b1, 12'd100);
        drain();
        expect_single("R5", HV, 12'hFFF, 1'b1, 1'b1, 1'b0);
        do_write(3, k1, 4'd6, 1'b1, 1'b0);
        ncap = 0;
        send(k1, 8'h10, 1'b1, 12'd100);
        drain();
        expect_single("R8", 6, 100, 1'b1, 1'b0, 1'b0);
        do_write(3, k1, 4'd6, 1'b0, 1'b0);
        ncap = 0;
        send(k1, 8'h10, 1'b1, 12'd100);
        drain();
        expect_single("R8", HV, 12'hFFF, 1'b1, 1'b1, 1'b0);
        do_write(3, k1, 4'd5, 1'b1, 1'b0);
    endtask

    task automatic t_backpressure();
        ncap = 0;
        set_ready(1'b0);
        send(k1, 8'h10, 1'b1, 12'd100);
        repeat (3) @(negedge clk);
        chk("R9", "held valid", 128'(out_valid), 128'd1);
        chk("R9", "held port", 128'(out_port), 128'd5);
        chk("R9", "none taken", 128'(ncap), 128'd0);
        chk("R9", "in_ready low", 128'(in_ready), 128'd0);
        set_ready(1'b1);
        send(k3, 8'h00, 1'b1, 12'd3);
        drain();
        chk("R9", "count", 128'(ncap), 128'd2);
        chk("R9", "first port", 128'(cap_port[0]), 128'd5);
        chk("R9", "second port", 128'(cap_port[1]), 128'(HV));
        chk("R9", "second exc", 128'(cap_exc[1]), 128'd1);
        ncap = 0;
        set_ready(1'b0);
        send(k1, 8'h01, 1'b1, 12'd100);
        repeat (3) @(negedge clk);
        chk("R6", "stalled orig port", 128'(out_port), 128'd5);
        chk("R6", "stalled orig copy", 128'(out_copy), 128'd0);
        chk("R6", "in_ready low", 128'(in_ready), 128'd0);
        set_ready(1'b1);
        drain();
        chk("R6", "count after stall", 128'(ncap), 128'd2);
        chk("R6", "copy after stall", 128'(cap_copy[1]), 128'd1);
        chk("R6", "consecutive", 128'(cap_cyc[1]), 128'(cap_cyc[0] + 1));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        k1  = mk(32'h0A000001, 32'h0A000002, 16'd1234, 16'd80, PROTO_TCP);
        k1b = k1 ^ {{(KEY_W-9){1'b0}}, 1'b1, 8'h00};
        k2  = mk(32'hC0A80001, 32'hC0A80002, 16'd5000, 16'd53, 8'd17);
        k3  = mk(32'h01020304, 32'h05060708, 16'd1, 16'd2, PROTO_TCP);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_key = '0; in_tcp_flags = '0; in_vlan_present = 1'b0; in_vlan_id = '0;
        wr_en = 1'b0; wr_idx = '0; wr_key = '0; wr_port = '0; wr_valid = 1'b0; wr_stale = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_miss();
        t_term();
        t_stale();
        t_backpressure();
        done = 1'b1;
        finish_run();
    end
endmodule